// File: doc/BRIEF.md
# Write-Masked Queue Control Register Bank

This block holds the control state for a set of transmit queues (sixteen by default). For every queue it keeps an empty flag, an active flag, a channel number, a window-space-left flag, a mode bit that selects block-acknowledge operation or strict in-order operation, and a chain-mode select bit. Software reaches the state through a simple bus with an address, write data, a write enable and read data. The flag and field outputs go straight to the scheduling logic beside it.

Every word written to the empty-state register or a queue status register carries its own per-bit write enables in its upper bits. Software can therefore change one field, or one queue's empty flag, without first reading the register back. The scheduler has its own update ports for the empty flags and the window-space-left flags. When the host and the scheduler touch the same bit in the same cycle, the host write wins.

The command queue, queue 4 by default, is locked into in-order mode. Its mode bit can never be set.

Top module: `qctl_regs`

## Requirements
- R1: After reset every empty flag is 1. Every active flag, channel number, window-space-left flag, mode bit and chain-select bit is 0.
- R2: The empty-state register is at address 0x00. A write updates empty flag i to wdata bit i only when wdata bit 16+i is 1, and leaves the other flags unchanged. A read returns the flags in bits 15:0 and zero in bits 31:16.
- R3: The status register of queue q is at address 0x40+q. Its fields are: bit 0 active, bits 4:1 channel number, bit 5 window-space-left, and bit 8 mode (1 block-acknowledge, 0 in-order). A write changes status bit k (k from 0 to 9) only when wdata bit 10+k is 1.
- R4: Status bits 6, 7 and 9, and status bits 31:10, always read as zero and ignore writes.
- R5: The chain-select register is at address 0x01. A write loads wdata bits 15:0 (one bit per queue), and a read returns them with bits 31:16 as zero.
- R6: The mode bit of the command queue (queue 4) always stays 0, including after a write that enables bit 8 with a 1.
- R7: When schedEmptyWe bit i is 1, empty flag i takes schedEmptyVal bit i on the next clock edge, unless a host write changes that same flag.
- R8: When schedWslWe bit q is 1, the window-space-left flag of queue q takes schedWslVal bit q on the next clock edge, unless a host write changes that same flag.
- R9: When a host write and a scheduler update hit the same bit in the same cycle, the host value is stored. Bits in the same cycle that the host write does not enable still take the scheduler value.
- R10: Reads at unmapped addresses return zero, and writes to them change no state.
- R11: The outputs always show the stored state. Queue q's channel number is at queueChannel[4q+3:4q].
- R12: Read data is combinational: regRdData reflects regAddr and the stored state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Host write strobe |
| regAddr | input | 8 | Host word address |
| regWrData | input | 32 | Host write data including the per-bit enables |
| regRdData | output | 32 | Host read data |
| schedEmptyWe | input | 16 | Scheduler per-queue empty-flag update enable |
| schedEmptyVal | input | 16 | Scheduler empty-flag values |
| schedWslWe | input | 16 | Scheduler per-queue window-space-left update enable |
| schedWslVal | input | 16 | Scheduler window-space-left values |
| queueEmpty | output | 16 | Empty flag per queue |
| queueActive | output | 16 | Active flag per queue |
| queueWsl | output | 16 | Window-space-left flag per queue |
| queueAckMode | output | 16 | Mode bit per queue (1 block-acknowledge) |
| queueChannel | output | 64 | Channel number per queue, 4 bits each |
| chainSel | output | 16 | Chain-mode select per queue |

## Verification
The hardest case to reach from the ports is a host write and a scheduler update landing on the same flag in the same cycle, while other flags in that cycle are updated by the scheduler alone. The bench drives the scheduler ports in the same cycle as a masked host write. It picks masks that cover only some of the bits the scheduler is updating, so that the host-wins bits and the scheduler-only bits can both be checked in a single read. Sweeps of mask and data patterns over every queue cover the command-queue lock and the reserved status bits.

// File: rtl/qctl_pkg.sv
package qctl_pkg;
  localparam int IDX_W = 8;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int CHAN_W = 4;
  localparam int ST_FIELD_W = 10;
  localparam int ST_MASK_LO = 10;
  localparam int ST_ACTIVE = 0;
  localparam int ST_CHAN_LO = 1;
  localparam int ST_WSL = 5;
  localparam int ST_ACK = 8;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_EMPTY,
    RD_CHAIN,
    RD_STATUS
  } rdSel_e;

  typedef struct packed {
    logic             emptyWr;
    logic             chainWr;
    logic             statusWr;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] queueIdx;
  } regStrobe_t;
endpackage

// File: rtl/qctl_ctrl.sv
module qctl_ctrl
  import qctl_pkg::*;
#(
  parameter int NUM_QUEUES  = 16,
  parameter int ADDR_W      = 8,
  parameter int EMPTY_ADDR  = 'h00,
  parameter int CHAIN_ADDR  = 'h01,
  parameter int STATUS_BASE = 'h40
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] EMPTY_A  = ADDR_W'(EMPTY_ADDR);
  localparam logic [ADDR_W-1:0] CHAIN_A  = ADDR_W'(CHAIN_ADDR);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_BASE);
  localparam logic [ADDR_W-1:0] NQ_A     = ADDR_W'(NUM_QUEUES);

  logic [ADDR_W-1:0] offs;
  logic              inStatus;

  always_comb begin
    offs     = regAddr - STATUS_A;
    inStatus = (regAddr >= STATUS_A) && (offs < NQ_A);
  end

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_NONE;
    strobe.queueIdx = IDX_W'(offs);
    if (regAddr == EMPTY_A) begin
      strobe.rdSel   = RD_EMPTY;
      strobe.emptyWr = regWrEn;
    end else if (regAddr == CHAIN_A) begin
      strobe.rdSel   = RD_CHAIN;
      strobe.chainWr = regWrEn;
    end else if (inStatus) begin
      strobe.rdSel    = RD_STATUS;
      strobe.statusWr = regWrEn;
    end
  end
endmodule

// File: rtl/qctl_qstat.sv
module qctl_qstat
  import qctl_pkg::*;
#(
  parameter bit IS_CMD = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              schedWslWe,
  input  logic              schedWslVal,
  output logic              active,
  output logic [CHAN_W-1:0] chan,
  output logic              wsl,
  output logic              ackMode
);
  logic [ST_FIELD_W-1:0] bitEn;
  logic [ST_FIELD_W-1:0] bitVal;

  always_comb begin
    bitEn  = wrEn ? wrData[ST_MASK_LO +: ST_FIELD_W] : '0;
    bitVal = wrData[ST_FIELD_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      chan    <= '0;
      wsl     <= 1'b0;
      ackMode <= 1'b0;
    end else begin
      if (bitEn[ST_ACTIVE]) active <= bitVal[ST_ACTIVE];
      for (int k = 0; k < CHAN_W; k++) begin
        if (bitEn[ST_CHAN_LO+k]) chan[k] <= bitVal[ST_CHAN_LO+k];
      end
      if (bitEn[ST_WSL]) wsl <= bitVal[ST_WSL];
      else if (schedWslWe) wsl <= schedWslVal;
      if (!IS_CMD && bitEn[ST_ACK]) ackMode <= bitVal[ST_ACK];
    end
  end
endmodule

// File: rtl/qctl_dpath.sv
module qctl_dpath
  import qctl_pkg::*;
#(
  parameter int NUM_QUEUES = 16,
  parameter int CMD_QUEUE  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  regStrobe_t                   strobe,
  input  logic [DATA_W-1:0]            regWrData,
  output logic [DATA_W-1:0]            regRdData,
  input  logic [NUM_QUEUES-1:0]        schedEmptyWe,
  input  logic [NUM_QUEUES-1:0]        schedEmptyVal,
  input  logic [NUM_QUEUES-1:0]        schedWslWe,
  input  logic [NUM_QUEUES-1:0]        schedWslVal,
  output logic [NUM_QUEUES-1:0]        queueEmpty,
  output logic [NUM_QUEUES-1:0]        queueActive,
  output logic [NUM_QUEUES-1:0]        queueWsl,
  output logic [NUM_QUEUES-1:0]        queueAckMode,
  output logic [NUM_QUEUES*CHAN_W-1:0] queueChannel,
  output logic [NUM_QUEUES-1:0]        chainSel
);
  localparam int QW = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;

  logic [NUM_QUEUES-1:0] emptyMask;
  logic [NUM_QUEUES-1:0] emptyData;
  logic [DATA_W-1:0]     statusWord [NUM_QUEUES];
  logic [QW-1:0]         qSel;

  always_comb begin
    emptyMask = strobe.emptyWr ? regWrData[HALF_W +: NUM_QUEUES] : '0;
    emptyData = regWrData[NUM_QUEUES-1:0];
    qSel      = strobe.queueIdx[QW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      queueEmpty <= '1;
    end else begin
      for (int i = 0; i < NUM_QUEUES; i++) begin
        if (emptyMask[i]) queueEmpty[i] <= emptyData[i];
        else if (schedEmptyWe[i]) queueEmpty[i] <= schedEmptyVal[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainSel <= '0;
    else if (strobe.chainWr) chainSel <= regWrData[NUM_QUEUES-1:0];
  end

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
    logic qWr;
    assign qWr = strobe.statusWr && (qSel == QW'(q));

    qctl_qstat #(.IS_CMD(q == CMD_QUEUE)) u_stat (
      .clk        (clk),
      .rstN       (rstN),
      .wrEn       (qWr),
      .wrData     (regWrData),
      .schedWslWe (schedWslWe[q]),
      .schedWslVal(schedWslVal[q]),
      .active     (queueActive[q]),
      .chan       (queueChannel[q*CHAN_W +: CHAN_W]),
      .wsl        (queueWsl[q]),
      .ackMode    (queueAckMode[q])
    );

    always_comb begin
      statusWord[q]                         = '0;
      statusWord[q][ST_ACTIVE]              = queueActive[q];
      statusWord[q][ST_CHAN_LO +: CHAN_W]   = queueChannel[q*CHAN_W +: CHAN_W];
      statusWord[q][ST_WSL]                 = queueWsl[q];
      statusWord[q][ST_ACK]                 = queueAckMode[q];
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (strobe.rdSel)
      RD_EMPTY:  regRdData[NUM_QUEUES-1:0] = queueEmpty;
      RD_CHAIN:  regRdData[NUM_QUEUES-1:0] = chainSel;
      RD_STATUS: regRdData = statusWord[qSel];
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/qctl_regs.sv
module qctl_regs
  import qctl_pkg::*;
#(
  parameter int NUM_QUEUES  = 16,
  parameter int CMD_QUEUE   = 4,
  parameter int ADDR_W      = 8,
  parameter int EMPTY_ADDR  = 'h00,
  parameter int CHAIN_ADDR  = 'h01,
  parameter int STATUS_BASE = 'h40
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWrEn,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [31:0]                  regWrData,
  output logic [31:0]                  regRdData,
  input  logic [NUM_QUEUES-1:0]        schedEmptyWe,
  input  logic [NUM_QUEUES-1:0]        schedEmptyVal,
  input  logic [NUM_QUEUES-1:0]        schedWslWe,
  input  logic [NUM_QUEUES-1:0]        schedWslVal,
  output logic [NUM_QUEUES-1:0]        queueEmpty,
  output logic [NUM_QUEUES-1:0]        queueActive,
  output logic [NUM_QUEUES-1:0]        queueWsl,
  output logic [NUM_QUEUES-1:0]        queueAckMode,
  output logic [NUM_QUEUES*4-1:0]      queueChannel,
  output logic [NUM_QUEUES-1:0]        chainSel
);
  regStrobe_t strobe;

  qctl_ctrl #(
    .NUM_QUEUES (NUM_QUEUES),
    .ADDR_W     (ADDR_W),
    .EMPTY_ADDR (EMPTY_ADDR),
    .CHAIN_ADDR (CHAIN_ADDR),
    .STATUS_BASE(STATUS_BASE)
  ) u_ctrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  qctl_dpath #(
    .NUM_QUEUES(NUM_QUEUES),
    .CMD_QUEUE (CMD_QUEUE)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .schedEmptyWe (schedEmptyWe),
    .schedEmptyVal(schedEmptyVal),
    .schedWslWe   (schedWslWe),
    .schedWslVal  (schedWslVal),
    .queueEmpty   (queueEmpty),
    .queueActive  (queueActive),
    .queueWsl     (queueWsl),
    .queueAckMode (queueAckMode),
    .queueChannel (queueChannel),
    .chainSel     (chainSel)
  );
endmodule

// File: rtl/qctl_regs_chk.sv
module qctl_regs_chk #(
  parameter int NUM_QUEUES  = 16,
  parameter int CMD_QUEUE   = 4,
  parameter int ADDR_W      = 8,
  parameter int EMPTY_ADDR  = 'h00,
  parameter int CHAIN_ADDR  = 'h01,
  parameter int STATUS_BASE = 'h40
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    regWrEn,
  input logic [ADDR_W-1:0]       regAddr,
  input logic [31:0]             regWrData,
  input logic [31:0]             regRdData,
  input logic [NUM_QUEUES-1:0]   schedEmptyWe,
  input logic [NUM_QUEUES-1:0]   schedEmptyVal,
  input logic [NUM_QUEUES-1:0]   schedWslWe,
  input logic [NUM_QUEUES-1:0]   schedWslVal,
  input logic [NUM_QUEUES-1:0]   queueEmpty,
  input logic [NUM_QUEUES-1:0]   queueWsl,
  input logic [NUM_QUEUES-1:0]   queueAckMode,
  input logic [NUM_QUEUES-1:0]   chainSel
);
  logic                  hostEmptyWr;
  logic                  hostChainWr;
  logic                  isStatusAddr;
  logic                  isMapped;
  logic [NUM_QUEUES-1:0] hostEmptyMask;
  logic [NUM_QUEUES-1:0] hostWslMask;

  always_comb begin
    hostEmptyWr   = regWrEn && (int'(regAddr) == EMPTY_ADDR);
    hostChainWr   = regWrEn && (int'(regAddr) == CHAIN_ADDR);
    isStatusAddr  = (int'(regAddr) >= STATUS_BASE) && (int'(regAddr) < STATUS_BASE + NUM_QUEUES);
    isMapped      = isStatusAddr || (int'(regAddr) == EMPTY_ADDR) || (int'(regAddr) == CHAIN_ADDR);
    hostEmptyMask = hostEmptyWr ? regWrData[16 +: NUM_QUEUES] : '0;
    for (int q = 0; q < NUM_QUEUES; q++) begin
      hostWslMask[q] = regWrEn && (int'(regAddr) == STATUS_BASE + q) && regWrData[15];
    end
  end

  assert_empty_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    hostEmptyWr |=> (((queueEmpty ^ $past(regWrData[NUM_QUEUES-1:0])) & $past(hostEmptyMask)) == '0));

  assert_empty_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostEmptyMask == '0 && schedEmptyWe == '0) |=> $stable(queueEmpty));

  assert_status_reserved_R4: assert property (@(posedge clk) disable iff (!rstN)
    isStatusAddr |-> (regRdData[31:9] == '0 && regRdData[7:6] == 2'b00));

  assert_chain_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostChainWr |=> (chainSel == $past(regWrData[NUM_QUEUES-1:0])));

  assert_cmd_inorder_R6: assert property (@(posedge clk) disable iff (!rstN)
    queueAckMode[CMD_QUEUE] == 1'b0);

  assert_sched_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((queueEmpty ^ $past(schedEmptyVal)) & $past(schedEmptyWe & ~hostEmptyMask)) == '0));

  assert_sched_wsl_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((queueWsl ^ $past(schedWslVal)) & $past(schedWslWe & ~hostWslMask)) == '0));

  assert_host_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostEmptyMask & schedEmptyWe) != '0 |=>
      (((queueEmpty ^ $past(regWrData[NUM_QUEUES-1:0])) & $past(hostEmptyMask & schedEmptyWe)) == '0));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped |-> (regRdData == '0));
endmodule

bind qctl_regs qctl_regs_chk #(
  .NUM_QUEUES (NUM_QUEUES),
  .CMD_QUEUE  (CMD_QUEUE),
  .ADDR_W     (ADDR_W),
  .EMPTY_ADDR (EMPTY_ADDR),
  .CHAIN_ADDR (CHAIN_ADDR),
  .STATUS_BASE(STATUS_BASE)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regAddr      (regAddr),
  .regWrData    (regWrData),
  .regRdData    (regRdData),
  .schedEmptyWe (schedEmptyWe),
  .schedEmptyVal(schedEmptyVal),
  .schedWslWe   (schedWslWe),
  .schedWslVal  (schedWslVal),
  .queueEmpty   (queueEmpty),
  .queueWsl     (queueWsl),
  .queueAckMode (queueAckMode),
  .chainSel     (chainSel)
);

// File: tb/qctl_regs_test.sv
module qctl_regs_test;
  localparam int NQ = 16;
  localparam int CMDQ = 4;
  localparam logic [7:0] A_EMPTY = 8'h00;
  localparam logic [7:0] A_CHAIN = 8'h01;
  localparam logic [7:0] A_STAT  = 8'h40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [7:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [NQ-1:0] schedEmptyWe = '0, schedEmptyVal = '0, schedWslWe = '0, schedWslVal = '0;
  logic [NQ-1:0] queueEmpty, queueActive, queueWsl, queueAckMode, chainSel;
  logic [NQ*4-1:0] queueChannel;

  int checks = 0;
  int failures = 0;

  logic [NQ-1:0] expEmpty;
  logic [NQ-1:0] expChain;
  logic [9:0]    expStat [NQ];

  always #2 clk = ~clk;

  qctl_regs uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .schedEmptyWe(schedEmptyWe), .schedEmptyVal(schedEmptyVal),
    .schedWslWe(schedWslWe), .schedWslVal(schedWslVal),
    .queueEmpty(queueEmpty), .queueActive(queueActive), .queueWsl(queueWsl),
    .queueAckMode(queueAckMode), .queueChannel(queueChannel), .chainSel(chainSel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] writable(input int q);
    return (q == CMDQ) ? 10'h03F : 10'h13F;
  endfunction

  // one bus cycle: inputs set after a falling edge, captured at the next rising edge
  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [NQ-1:0] eWe, input logic [NQ-1:0] eVal,
                     input logic [NQ-1:0] wWe, input logic [NQ-1:0] wVal);
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d;
    schedEmptyWe = eWe; schedEmptyVal = eVal; schedWslWe = wWe; schedWslVal = wVal;
    @(negedge clk);
    regWrEn = 1'b0; schedEmptyWe = '0; schedWslWe = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, '0, '0, '0, '0);
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    chk(req, regRdData, exp);
  endtask

  task automatic modelStatus(input int q, input logic [31:0] d);
    logic [9:0] en;
    en = d[19:10] & writable(q);
    expStat[q] = (expStat[q] & ~en) | (d[9:0] & en);
  endtask

  task automatic checkAll(input string req);
    rdChk(req, A_EMPTY, {16'h0, expEmpty});
    rdChk(req, A_CHAIN, {16'h0, expChain});
    for (int q = 0; q < NQ; q++) begin
      rdChk(req, A_STAT + 8'(q), {22'h0, expStat[q]});
      chk({req, " R11 outputs"},
          {queueActive[q], queueWsl[q], queueAckMode[q], queueChannel[q*4 +: 4]},
          {expStat[q][0], expStat[q][5], expStat[q][8], expStat[q][4:1]});
    end
    chk({req, " R11 empty/chain outputs"}, {queueEmpty, chainSel}, {expEmpty, expChain});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] m, v;
    expEmpty = '1;
    expChain = '0;
    for (int q = 0; q < NQ; q++) expStat[q] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R12 combinational read
    checkAll("R1 reset");

    // R2 empty register with masked writes
    for (int n = 0; n < 40; n++) begin
      m = 16'(n * 40503) ^ 16'(n << 3);
      v = 16'(n * 15133 + 7);
      wr(A_EMPTY, {m, v});
      expEmpty = (expEmpty & ~m) | (v & m);
      rdChk("R2 empty masked write", A_EMPTY, {16'h0, expEmpty});
      chk("R2 empty output", {16'h0, queueEmpty}, {16'h0, expEmpty});
    end
    wr(A_EMPTY, {16'h0000, 16'hFFFF ^ expEmpty});
    rdChk("R2 zero mask keeps flags", A_EMPTY, {16'h0, expEmpty});

    // R3 R4 R6 status registers
    for (int q = 0; q < NQ; q++) begin
      for (int n = 0; n < 6; n++) begin
        d = {12'hFFF, 10'((q * 37 + n * 113) & 10'h3FF), 10'((q * 91 + n * 59) ^ 10'h2AA)};
        wr(A_STAT + 8'(q), d);
        modelStatus(q, d);
        rdChk("R3 status masked write", A_STAT + 8'(q), {22'h0, expStat[q]});
      end
      wr(A_STAT + 8'(q), 32'hFFFF_FFFF);
      modelStatus(q, 32'hFFFF_FFFF);
      rdChk("R4 reserved status bits read zero", A_STAT + 8'(q),
            (q == CMDQ) ? 32'h0000_003F : 32'h0000_013F);
    end
    chk("R6 command queue in-order", {31'h0, queueAckMode[CMDQ]}, 32'h0);
    wr(A_STAT + 8'(CMDQ), 32'h0004_0100);
    rdChk("R6 command queue mode write ignored", A_STAT + 8'(CMDQ), {22'h0, expStat[CMDQ]});
    // clear status except wsl so later checks see distinct values
    for (int q = 0; q < NQ; q++) begin
      d = {12'h0, 10'h3DF, 10'(q << 1)};
      wr(A_STAT + 8'(q), d);
      modelStatus(q, d);
    end
    checkAll("R3 per-field status");

    // R5 chain select
    wr(A_CHAIN, 32'hFFFF_A5C3);
    expChain = 16'hA5C3;
    rdChk("R5 chain write", A_CHAIN, 32'h0000_A5C3);
    wr(A_CHAIN, 32'h1234_FFFF);
    expChain = 16'hFFFF;
    rdChk("R5 chain reserved bits zero", A_CHAIN, 32'h0000_FFFF);

    // R7 scheduler empty update alone
    cyc(1'b0, A_EMPTY, '0, 16'h00FF, 16'h0F0F, '0, '0);
    expEmpty = (expEmpty & ~16'h00FF) | (16'h0F0F & 16'h00FF);
    rdChk("R7 scheduler empty update", A_EMPTY, {16'h0, expEmpty});

    // R9 collision on empty flags
    cyc(1'b1, A_EMPTY, {16'h0F0F, 16'h0000}, 16'hFFFF, 16'hFFFF, '0, '0);
    expEmpty = 16'hF0F0;
    rdChk("R9 host wins on empty, scheduler elsewhere", A_EMPTY, {16'h0, expEmpty});

    // R8 scheduler wsl update alone
    cyc(1'b0, A_EMPTY, '0, '0, '0, 16'hFFFF, 16'hFFFF);
    for (int q = 0; q < NQ; q++) expStat[q][5] = 1'b1;
    chk("R8 scheduler wsl update", {16'h0, queueWsl}, 32'h0000_FFFF);

    // R9 collision on wsl of queue 3
    cyc(1'b1, A_STAT + 8'd3, {12'h0, 10'h020, 10'h000}, '0, '0, 16'hFFFF, 16'hFFFF);
    chk("R9 host wins on wsl", {16'h0, queueWsl}, 32'h0000_FFF7);
    expStat[3][5] = 1'b0;
    cyc(1'b1, A_STAT + 8'd3, {12'h0, 10'h001, 10'h001}, '0, '0, 16'h0008, 16'h0008);
    expStat[3][0] = 1'b1; expStat[3][5] = 1'b1;
    rdChk("R9 unmasked wsl takes scheduler value", A_STAT + 8'd3, {22'h0, expStat[3]});

    // R10 unmapped addresses
    rdChk("R10 unmapped read", 8'h02, 32'h0);
    rdChk("R10 unmapped read", 8'h3F, 32'h0);
    rdChk("R10 unmapped read", 8'h50, 32'h0);
    rdChk("R10 unmapped read", 8'hFF, 32'h0);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h3F, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'hFF, 32'h0000_0000);
    checkAll("R10 unmapped writes change nothing");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule